// File: doc/BRIEF.md
# Fixed-Latency Bit Scan Unit

This block finds the position of a set bit in a 32-bit operand. A select input picks the direction. Reverse scan returns the index of the most significant set bit. Forward scan returns the index of the least significant set bit. The search is done by a parallel priority encoder, so every operand takes exactly one clock from input to result, whatever its bit pattern. This removes any timing side channel that depends on the data.

The operand is split into 8-bit groups. Each group reports whether it holds a set bit and where that bit sits inside the group. A merge stage then picks the winning group, using the same direction rule, and joins the group number with the local position. The result goes into a destination register. An all-zero operand raises a zero flag and leaves the destination register at its earlier value, so the previous result stays visible.

Top module: `bscan_unit`

## Requirements
- R1: With `in_op` = 1 (reverse), a valid nonzero operand yields `out_index` equal to the position of its highest set bit.
- R2: With `in_op` = 0 (forward), a valid nonzero operand yields `out_index` equal to the position of its lowest set bit.
- R3: A valid all-zero operand sets `out_zero` to 1 and leaves `out_index` at the value it held before, in either direction.
- R4: A valid nonzero operand clears `out_zero` to 0.
- R5: The result and flag appear on the clock edge after the input is accepted. `out_valid` is high for exactly that one cycle, with the same latency for every operand value.
- R6: While `in_valid` is low, `out_index` and `out_zero` hold their values, whatever `in_operand` and `in_op` carry.
- R7: A synchronous active-high reset clears `out_index`, `out_zero` and `out_valid` to 0.
- R8: Operands presented on consecutive cycles each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and select are valid this cycle |
| in_op | input | 1 | Scan direction: 0 forward (lowest bit), 1 reverse (highest bit) |
| in_operand | input | 32 | Operand to scan |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_index | output | 5 | Destination register: bit position found |
| out_zero | output | 1 | Set when the last accepted operand was zero |

## Verification
The only state in this block is the destination register, the zero flag and the valid bit. If any of them goes wrong, the error shows at the ports on the cycle right after the input that caused it. A wrong group choice or a wrong local position gives an index off by a multiple of eight or by a few bits. Walking a single bit through every position in both directions catches both cases. A zero operand that overwrites the destination shows as soon as the index is read after that zero. A latch of inputs while idle shows as a changed index on the next idle cycle.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [0:0] {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_op_e;

endpackage

// File: rtl/bscan_group.sv
// One slice of the parallel encoder: reports whether the slice holds a set
// bit and the slice-local position chosen by the scan direction.
module bscan_group
  import bscan_pkg::*;
#(
  parameter int GW = 8,
  localparam int LW = $clog2(GW)
) (
  input  logic [GW-1:0] bits,
  input  scan_op_e      op,
  output logic          hit,
  output logic [LW-1:0] pos
);

  always_comb begin
    hit = |bits;
    pos = '0;
    if (op == SCAN_REV) begin
      // later (higher) matches overwrite earlier ones
      for (int i = 0; i < GW; i++) begin
        if (bits[i]) pos = LW'(i);
      end
    end else begin
      for (int i = GW - 1; i >= 0; i--) begin
        if (bits[i]) pos = LW'(i);
      end
    end
  end

endmodule

// File: rtl/bscan_merge.sv
// Picks the winning slice by the same direction rule and forms the full index.
module bscan_merge
  import bscan_pkg::*;
#(
  parameter int NG = 4,
  parameter int LW = 3,
  localparam int GB = $clog2(NG)
) (
  input  logic [NG-1:0]    hit,
  input  logic [NG*LW-1:0] pos_flat,
  input  scan_op_e         op,
  output logic             any,
  output logic [GB+LW-1:0] idx
);

  logic [GB-1:0] grp;

  always_comb begin
    any = |hit;
    grp = '0;
    if (op == SCAN_REV) begin
      for (int g = 0; g < NG; g++) begin
        if (hit[g]) grp = GB'(g);
      end
    end else begin
      for (int g = NG - 1; g >= 0; g--) begin
        if (hit[g]) grp = GB'(g);
      end
    end
    idx = {grp, pos_flat[grp*LW +: LW]};
  end

endmodule

// File: rtl/bscan_unit.sv
module bscan_unit
  import bscan_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int LOC_W  = $clog2(GROUP_W),
  localparam int NGRP   = DATA_W / GROUP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_op,
  input  logic [DATA_W-1:0] in_operand,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_index,
  output logic              out_zero
);

  scan_op_e               op_sel;
  logic [NGRP-1:0]        grp_hit;
  logic [NGRP*LOC_W-1:0]  grp_pos;
  logic                   scan_any;
  logic [IDX_W-1:0]       scan_idx;

  assign op_sel = scan_op_e'(in_op);

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    bscan_group #(.GW(GROUP_W)) i_group (
      .bits (in_operand[g*GROUP_W +: GROUP_W]),
      .op   (op_sel),
      .hit  (grp_hit[g]),
      .pos  (grp_pos[g*LOC_W +: LOC_W])
    );
  end

  bscan_merge #(.NG(NGRP), .LW(LOC_W)) i_merge (
    .hit      (grp_hit),
    .pos_flat (grp_pos),
    .op       (op_sel),
    .any      (scan_any),
    .idx      (scan_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_index <= '0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (scan_any) begin
          out_index <= scan_idx;
          out_zero  <= 1'b0;
        end else begin
          out_zero  <= 1'b1;
        end
      end
    end
  end

  // R1: the found bit is set and nothing above it is
  p_rev_top_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op && in_operand != '0)
      |=> (($past(in_operand) >> out_index) == DATA_W'(1)));

  // R2: the found bit equals the isolated lowest set bit
  p_fwd_low_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op && in_operand != '0)
      |=> ((DATA_W'(1) << out_index) ==
           ($past(in_operand) & (~$past(in_operand) + DATA_W'(1)))));

  p_zero_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand == '0) |=> (out_zero && $stable(out_index)));

  p_flag_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_operand != '0) |=> !out_zero);

  p_lat_one_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_lat_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_index) && $stable(out_zero)));

endmodule

// File: tb/test_bscan_unit.sv
`timescale 1ns/1ps
module test_bscan_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_op;
  logic [31:0] in_operand;
  logic        out_valid;
  logic [4:0]  out_index;
  logic        out_zero;

  int checks = 0;
  int fails  = 0;
  int exp_idx = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bscan_unit i_bscan_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_operand(in_operand), .out_valid(out_valid),
    .out_index(out_index), .out_zero(out_zero)
  );

  function automatic int ref_hi(input logic [31:0] v);
    int r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int ref_lo(input logic [31:0] v);
    int r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one operand, check result one cycle later and the valid pulse width
  task automatic scan_one(input string req, input logic op, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_operand = v;
    @(negedge clk);
    in_valid = 1'b0; in_operand = ~v;
    if (v != 0) exp_idx = op ? ref_hi(v) : ref_lo(v);
    chk(req, "index", int'(out_index), exp_idx);
    chk(req, "zero", int'(out_zero), (v == 0) ? 1 : 0);
    chk("R5", "valid", int'(out_valid), 1);
    @(negedge clk);
    chk("R5", "valid drop", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_op = 1'b0; in_operand = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7", "reset index", int'(out_index), 0);
    chk("R7", "reset zero", int'(out_zero), 0);
    chk("R7", "reset valid", int'(out_valid), 0);
    exp_idx = 0;
  endtask

  task automatic t_walk;
    for (int i = 0; i < 32; i++) scan_one("R1", 1'b1, 32'd1 << i);
    for (int i = 0; i < 32; i++) scan_one("R2", 1'b0, 32'd1 << i);
  endtask

  task automatic t_patterns;
    scan_one("R1", 1'b1, 32'hFFFF_FFFF);
    scan_one("R2", 1'b0, 32'hFFFF_FFFF);
    scan_one("R1", 1'b1, 32'h8000_0001);
    scan_one("R2", 1'b0, 32'h8000_0001);
    scan_one("R1", 1'b1, 32'h0001_0100);
    scan_one("R2", 1'b0, 32'h0001_0100);
    scan_one("R1", 1'b1, 32'h00F0_0000);
    scan_one("R2", 1'b0, 32'h0000_0080);
    scan_one("R4", 1'b1, 32'h0000_0C00);
  endtask

  task automatic t_zero;
    scan_one("R4", 1'b1, 32'h0400_0000);
    scan_one("R3", 1'b1, 32'h0);
    scan_one("R3", 1'b0, 32'h0);
    scan_one("R4", 1'b0, 32'h0000_0060);
    scan_one("R3", 1'b0, 32'h0);
  endtask

  task automatic t_idle;
    scan_one("R6", 1'b1, 32'h0000_2000);
    @(negedge clk);
    in_valid = 1'b0; in_op = 1'b0; in_operand = 32'h0000_0001;
    repeat (2) @(negedge clk);
    in_operand = 32'h0;
    repeat (2) @(negedge clk);
    chk("R6", "idle index", int'(out_index), 13);
    chk("R6", "idle zero", int'(out_zero), 0);
    chk("R6", "idle valid", int'(out_valid), 0);
  endtask

  task automatic t_back2back;
    logic [31:0] vals [6] = '{32'h0000_0010, 32'h8000_0000, 32'h0, 32'h0300_0000,
                              32'h0000_0001, 32'h0};
    logic        ops  [6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    int          eidx [6] = '{4, 31, 31, 24, 0, 0};
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b1; in_op = ops[k]; in_operand = vals[k];
      @(negedge clk);
      chk("R8", "b2b index", int'(out_index), eidx[k]);
      chk("R8", "b2b zero", int'(out_zero), (vals[k] == 0) ? 1 : 0);
      chk("R8", "b2b valid", int'(out_valid), 1);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R5", "b2b end valid", int'(out_valid), 0);
    exp_idx = 0;
  endtask

  task automatic t_reset_mid;
    scan_one("R1", 1'b1, 32'h0800_0000);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_operand = 32'h0;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    chk("R7", "mid reset index", int'(out_index), 0);
    chk("R7", "mid reset zero", int'(out_zero), 0);
    chk("R7", "mid reset valid", int'(out_valid), 0);
    exp_idx = 0;
  endtask

  initial begin
    t_reset();
    t_walk();
    t_patterns();
    t_zero();
    t_idle();
    t_back2back();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule